// File: doc/BRIEF.md
# Headset Insertion Detection Sequencer

This block is the control sequencer for a 3.5 mm headset jack. An active-low insertion trigger is debounced on a 1 ms time base. When the trigger has been held low without interruption for the selected period, the sequencer runs a fixed-length classification window. At the end of that window it samples a comparator result that reports where the microphone contact is, or that no microphone is present. From that result it drives four switch enables. These route microphone bias to the microphone contact and ground to the other contact. After the routing is settled, the sequencer pulls its interrupt low and, for a four-contact plug, its microphone-present flag.

A rising trigger is a removal. A removal during classification or after it clears the routing at once, raises the interrupt and releases the microphone flag. A removal wait then runs before the block returns to sleep. A host register port gives access to several things: sticky interrupt causes that clear when read, a manual switch override, an FM pass enable, a key-detect enable that is only accepted for a four-contact plug, a debounce length selector, and a start command that skips the debounce. The analog measurement, the switches and the serial bus sit outside the block.

Top module: `hs_detect_seq`

## Requirements
- R1: After reset, `sw_en` is 0, `int_n` and `mic_present_n` are 1, `asleep` is 1, `key_en` and `fm_en` are 0, and the control register (address 1) reads 6'h10, which is debounce selector 2.
- R2: A falling `trig_n` in sleep starts the insertion debounce. The debounce counts only while `trig_n` stays low and restarts from zero whenever `trig_n` is high. Its length comes from control bits [4:3]: 0 gives 0 ms, 1 gives 30 ms, 2 gives 90 ms and 3 gives 150 ms.
- R3: When the debounce ends, a classification window of CLASS_MS milliseconds runs, and `mic_loc` is then sampled. The encodings are 2'b00 for no microphone, 2'b01 for microphone on the sleeve, 2'b10 for microphone on ring2, and 2'b11, which is treated as no microphone. The result register (address 3) then reads 1 for a three-contact plug, 2 for microphone on the sleeve and 3 for microphone on ring2. It reads 0 when no plug is present.
- R4: `sw_en` bit 0 routes bias to the sleeve, bit 1 routes bias to ring2, bit 2 routes ground to the sleeve and bit 3 routes ground to ring2. The three plug types give 4'b0100 for a three-contact plug, 4'b1001 for microphone on the sleeve and 4'b0110 for microphone on ring2.
- R5: The switch enables reach their routed value at least one clock before `int_n` falls, and no later than `mic_present_n` falls.
- R6: `mic_present_n` goes low only after a four-contact result. It stays high for a three-contact result.
- R7: The status register (address 0) has a sticky insertion-done bit 0 and a sticky removal bit 1. `int_n` is low while either bit is set. A read of address 0 clears both bits, unless a new event arrives in the same cycle.
- R8: A rising `trig_n` during classification, routing or the active state has the following effect at the next clock edge: `sw_en` goes to 0, the result register goes to 0, `mic_present_n` goes to 1 and the removal bit is set. After REM_MS milliseconds `asleep` goes to 1.
- R9: A rising `trig_n` during the insertion debounce raises no interrupt. The block keeps waiting for a stable low.
- R10: While control bit 0 (manual) is 1, `sw_en` equals override register bits [3:0] (address 2) whatever the sequencer does, and the block does not enter sleep after a removal.
- R11: Control bit 2 (key detect) is taken only when the result register reads 2 or 3. A removal clears it.
- R12: Writing control bit 5 as 1 while asleep starts classification at once, with no debounce. The bit reads back as 0.
- R13: Control bit 1 drives `fm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_n | input | 1 | Synchronized jack trigger, low while a plug is in |
| mic_loc | input | 2 | Synchronized comparator result for the microphone position |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (a read of address 0 clears the status) |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 6 | Host write data |
| reg_rdata | output | 6 | Host read data, valid in the cycle of the access |
| sw_en | output | 4 | Switch enables for bias and ground routing |
| int_n | output | 1 | Interrupt, active low (open-drain level) |
| mic_present_n | output | 1 | Microphone present, active low (open-drain level) |
| fm_en | output | 1 | FM pass enable for the ground path |
| key_en | output | 1 | Key detection enable |
| asleep | output | 1 | High while the sequencer is in sleep |

## Verification
The properties assume that `trig_n` and `mic_loc` are already synchronous to `clk`. They also assume that `mic_loc` holds still across the edge at which classification ends, and that the host does not toggle manual mode in the cycle when an interrupt is raised. The stimulus changes every input only on the falling clock edge. It sets `mic_loc` before the trigger falls and holds it until the interrupt. It keeps debounce glitches shorter than the selected period, so that a glitch never completes a debounce by accident. Manual mode is changed only while the block is idle or waiting after a removal.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP    = 3'd0,
        ST_DEBOUNCE = 3'd1,
        ST_CLASSIFY = 3'd2,
        ST_ROUTE    = 3'd3,
        ST_ACTIVE   = 3'd4,
        ST_REMWAIT  = 3'd5
    } hsd_state_e;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_3POLE   = 2'd1,
        ACC_MIC_SLV = 2'd2,
        ACC_MIC_R2  = 2'd3
    } hsd_acc_e;

    localparam int SW_W       = 4;
    localparam int DEB_MAX_MS = 150;

    // debounce length for each selector value
    function automatic int unsigned deb_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 30;
            2'd2:    return 90;
            default: return DEB_MAX_MS;
        endcase
    endfunction

    function automatic hsd_acc_e classify(input logic [1:0] loc);
        case (loc)
            2'b01:   return ACC_MIC_SLV;
            2'b10:   return ACC_MIC_R2;
            default: return ACC_3POLE;
        endcase
    endfunction

    // bit0 bias->sleeve, bit1 bias->ring2, bit2 gnd->sleeve, bit3 gnd->ring2
    function automatic logic [SW_W-1:0] route_for(input hsd_acc_e acc);
        case (acc)
            ACC_3POLE:   return 4'b0100;
            ACC_MIC_SLV: return 4'b1001;
            ACC_MIC_R2:  return 4'b0110;
            default:     return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/hsd_tick.sv
module hsd_tick #(
    parameter int CLK_PER_MS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == W'(CLK_PER_MS - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hsd_fsm.sv
module hsd_fsm
    import hsd_pkg::*;
#(
    parameter int CLASS_MS = 100,
    parameter int REM_MS   = 50,
    parameter int CNT_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            trig_n,
    input  logic [1:0]      mic_loc,
    input  logic            start,
    input  logic            manual,
    input  logic [1:0]      deb_sel,
    output hsd_state_e      state,
    output logic [SW_W-1:0] sw,
    output hsd_acc_e        acc,
    output logic            mic,
    output logic            ev_ins,
    output logic            ev_rem
);
    typedef struct packed {
        hsd_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic            trig_prev;
        logic [SW_W-1:0] sw;
        hsd_acc_e        acc;
        logic            mic;
    } fsm_t;

    fsm_t q, d;
    logic fall, rise;
    logic [CNT_W-1:0] deb_lim;

    always_comb begin
        d       = q;
        ev_ins  = 1'b0;
        ev_rem  = 1'b0;
        fall    = q.trig_prev & ~trig_n;
        rise    = ~q.trig_prev & trig_n;
        deb_lim = CNT_W'(deb_ms(deb_sel));
        d.trig_prev = trig_n;

        case (q.st)
            ST_SLEEP: begin
                if (fall) begin
                    d.st  = ST_DEBOUNCE;
                    d.cnt = '0;
                end else if (start) begin
                    d.st  = ST_CLASSIFY;
                    d.cnt = '0;
                end
            end
            ST_DEBOUNCE: begin
                if (trig_n)                d.cnt = '0;
                else if (q.cnt >= deb_lim) begin
                    d.st  = ST_CLASSIFY;
                    d.cnt = '0;
                end else if (tick)         d.cnt = q.cnt + 1'b1;
            end
            ST_CLASSIFY: begin
                if (rise) begin
                    ev_rem = 1'b1;
                end else if (q.cnt >= CNT_W'(CLASS_MS)) begin
                    d.acc = classify(mic_loc);
                    d.sw  = route_for(classify(mic_loc));
                    d.st  = ST_ROUTE;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ROUTE: begin
                if (rise) begin
                    ev_rem = 1'b1;
                end else begin
                    ev_ins = 1'b1;
                    d.mic  = (q.acc == ACC_MIC_SLV) || (q.acc == ACC_MIC_R2);
                    d.st   = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (rise) ev_rem = 1'b1;
            end
            ST_REMWAIT: begin
                if (fall) begin
                    d.st  = ST_DEBOUNCE;
                    d.cnt = '0;
                end else if (q.cnt >= CNT_W'(REM_MS)) begin
                    if (!manual) d.st = ST_SLEEP;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_SLEEP;
        endcase

        if (ev_rem) begin
            d.st  = ST_REMWAIT;
            d.cnt = '0;
            d.sw  = '0;
            d.acc = ACC_NONE;
            d.mic = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_SLEEP;
            q.cnt       <= '0;
            q.trig_prev <= 1'b1;
            q.sw        <= '0;
            q.acc       <= ACC_NONE;
            q.mic       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state = q.st;
    assign sw    = q.sw;
    assign acc   = q.acc;
    assign mic   = q.mic;
endmodule

// File: rtl/hsd_regs.sv
module hsd_regs
    import hsd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            rd,
    input  logic [1:0]      addr,
    input  logic [5:0]      wdata,
    input  logic            ev_ins,
    input  logic            ev_rem,
    input  hsd_acc_e        acc,
    output logic [5:0]      rdata,
    output logic            manual,
    output logic            fm,
    output logic            key,
    output logic [1:0]      deb_sel,
    output logic [SW_W-1:0] ovr,
    output logic            start,
    output logic            irq
);
    typedef struct packed {
        logic            ins;
        logic            rem;
        logic            manual;
        logic            fm;
        logic            key;
        logic [1:0]      deb;
        logic [SW_W-1:0] ovr;
    } regs_t;

    regs_t q, d;
    logic four_pole;

    always_comb begin
        d         = q;
        four_pole = (acc == ACC_MIC_SLV) || (acc == ACC_MIC_R2);
        start     = wr && (addr == 2'd1) && wdata[5];
        if (wr) begin
            case (addr)
                2'd1: begin
                    d.manual = wdata[0];
                    d.fm     = wdata[1];
                    d.key    = wdata[2] & four_pole;
                    d.deb    = wdata[4:3];
                end
                2'd2:    d.ovr = wdata[3:0];
                default: ;
            endcase
        end
        if (rd && addr == 2'd0) begin
            d.ins = 1'b0;
            d.rem = 1'b0;
        end
        if (ev_ins) d.ins = 1'b1;
        if (ev_rem) begin
            d.rem = 1'b1;
            d.key = 1'b0;
        end

        case (addr)
            2'd0:    rdata = {4'b0, q.rem, q.ins};
            2'd1:    rdata = {1'b0, q.deb, q.key, q.fm, q.manual};
            2'd2:    rdata = {2'b0, q.ovr};
            default: rdata = {4'b0, acc};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.deb <= 2'd2;
        end else begin
            q <= d;
        end
    end

    assign manual  = q.manual;
    assign fm      = q.fm;
    assign key     = q.key;
    assign deb_sel = q.deb;
    assign ovr     = q.ovr;
    assign irq     = q.ins | q.rem;
endmodule

// File: rtl/hs_detect_seq.sv
module hs_detect_seq
    import hsd_pkg::*;
#(
    parameter int CLK_PER_MS = 250000,
    parameter int CLASS_MS   = 100,
    parameter int REM_MS     = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_n,
    input  logic [1:0] mic_loc,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [5:0] reg_wdata,
    output logic [5:0] reg_rdata,
    output logic [3:0] sw_en,
    output logic       int_n,
    output logic       mic_present_n,
    output logic       fm_en,
    output logic       key_en,
    output logic       asleep
);
    localparam int MAX_A  = (CLASS_MS > REM_MS) ? CLASS_MS : REM_MS;
    localparam int MAX_MS = (MAX_A > DEB_MAX_MS) ? MAX_A : DEB_MAX_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    logic            tick, start, manual, mic, ev_ins, ev_rem, irq;
    logic [1:0]      deb_sel;
    logic [SW_W-1:0] fsm_sw, ovr;
    hsd_state_e      fsm_state;
    hsd_acc_e        acc_type;

    hsd_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    hsd_fsm #(.CLASS_MS(CLASS_MS), .REM_MS(REM_MS), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_n(trig_n),
        .mic_loc(mic_loc), .start(start), .manual(manual),
        .deb_sel(deb_sel), .state(fsm_state), .sw(fsm_sw), .acc(acc_type),
        .mic(mic), .ev_ins(ev_ins), .ev_rem(ev_rem)
    );

    hsd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .ev_ins(ev_ins), .ev_rem(ev_rem), .acc(acc_type),
        .rdata(reg_rdata), .manual(manual), .fm(fm_en), .key(key_en),
        .deb_sel(deb_sel), .ovr(ovr), .start(start), .irq(irq)
    );

    assign sw_en         = manual ? ovr : fsm_sw;
    assign int_n         = ~irq;
    assign mic_present_n = ~mic;
    assign asleep        = (fsm_state == ST_SLEEP);
endmodule

// File: rtl/hsd_checker.sv
module hsd_checker
    import hsd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       trig_n,
    input logic [3:0] sw_en,
    input logic       int_n,
    input logic       mic_present_n,
    input logic       key_en,
    input logic       manual,
    input hsd_acc_e   acc_type,
    input hsd_state_e state,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       ev_ins,
    input logic       ev_rem
);
    AST_BIAS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !manual |-> $onehot0(sw_en[1:0])); // R4

    AST_GND_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && sw_en[0]) |-> (sw_en[3] && !sw_en[2])); // R4

    AST_ROUTE_BEFORE_INT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_n) && acc_type != ACC_NONE && !manual && !$past(manual))
        |-> ($stable(sw_en) && sw_en != 4'b0000)); // R5

    AST_ROUTE_BEFORE_MIC: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mic_present_n) && !manual && !$past(manual)) |-> $stable(sw_en)); // R5

    AST_MIC_FOUR_POLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mic_present_n |-> (acc_type == ACC_MIC_SLV || acc_type == ACC_MIC_R2)); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && !ev_ins && !ev_rem) |=> int_n); // R7

    AST_REMOVAL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CLASSIFY || state == ST_ROUTE || state == ST_ACTIVE) && $rose(trig_n))
        |=> (mic_present_n && !int_n && acc_type == ACC_NONE)); // R8

    AST_DEBOUNCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> ($past(state) != ST_DEBOUNCE)); // R9

    AST_KEY_FOUR_POLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_en |-> (acc_type == ACC_MIC_SLV || acc_type == ACC_MIC_R2)); // R11
endmodule

bind hs_detect_seq hsd_checker u_hsd_chk (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .sw_en(sw_en), .int_n(int_n),
    .mic_present_n(mic_present_n), .key_en(key_en), .manual(manual),
    .acc_type(acc_type), .state(fsm_state), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .ev_ins(ev_ins), .ev_rem(ev_rem)
);

// File: tb/hs_detect_seq_bench.sv
`timescale 1ns/1ps
module hs_detect_seq_bench;
    localparam int CPM = 4;
    localparam int CMS = 100;
    localparam int RMS = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_n = 1'b1;
    logic [1:0] mic_loc = 2'b00;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [5:0] reg_wdata = 6'd0;
    logic [5:0] reg_rdata;
    logic [3:0] sw_en;
    logic       int_n, mic_present_n, fm_en, key_en, asleep;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hs_detect_seq #(.CLK_PER_MS(CPM), .CLASS_MS(CMS), .REM_MS(RMS)) u_hs_detect_seq (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .mic_loc(mic_loc),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_en(sw_en),
        .int_n(int_n), .mic_present_n(mic_present_n), .fm_en(fm_en),
        .key_en(key_en), .asleep(asleep)
    );

    function automatic int exp_acc(input logic [1:0] loc);
        case (loc)
            2'b01:   return 2;
            2'b10:   return 3;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_sw(input int acc);
        case (acc)
            1:       return 4'b0100;
            2:       return 4'b1001;
            3:       return 4'b0110;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_deb(input int sel);
        case (sel)
            0:       return 0;
            1:       return 30;
            2:       return 90;
            default: return 150;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int lo, input int hi);
        chk(act >= lo && act <= hi, req, act, lo);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [5:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [5:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_ctrl(input bit man, input bit fm, input bit key, input int deb, input bit go);
        reg_write(2'd1, {go, 2'(deb), key, fm, man});
    endtask

    // glitches, then a stable low; returns cycles from last fall to int_n low
    task automatic detect(input logic [1:0] loc, input int glitches, output int cyc,
                          output logic [3:0] swp, output bit mic_early, output bit int_glitch);
        mic_loc = loc; int_glitch = 0; mic_early = 0; swp = 4'b0;
        for (int g = 0; g < glitches; g++) begin
            trig_n = 1'b0;
            repeat (5 + $urandom_range(0, 95)) begin
                @(negedge clk);
                if (!int_n) int_glitch = 1;
            end
            trig_n = 1'b1;
            repeat (1 + $urandom_range(0, 4)) begin
                @(negedge clk);
                if (!int_n) int_glitch = 1;
            end
        end
        trig_n = 1'b0;
        cyc = 0;
        while (cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (!int_n) break;
            if (!mic_present_n) mic_early = 1;
            swp = sw_en;
        end
    endtask

    // rising trigger, checks the immediate effect and the time to sleep
    task automatic remove_check(input bit man_on, input logic [3:0] man_sw);
        int cyc;
        trig_n = 1'b1;
        @(negedge clk);
        chk(int_n == 1'b0, "R8 int on removal", int_n, 0);
        chk(mic_present_n == 1'b1, "R8 mic released", mic_present_n, 1);
        chk(key_en == 1'b0, "R11 key cleared on removal", key_en, 0);
        if (man_on) chk(sw_en == man_sw, "R10 sw held on removal", sw_en, man_sw);
        else        chk(sw_en == 4'b0, "R8 sw cleared on removal", sw_en, 0);
        if (!man_on) begin
            cyc = 1;
            while (!asleep && cyc < 2000) begin
                @(negedge clk);
                cyc++;
            end
            chk_win("R8 removal wait to sleep", cyc, 4 * RMS - 6, 4 * RMS + 10);
        end
    endtask

    task automatic clear_status(input int exp);
        logic [5:0] v;
        reg_read(2'd0, v);
        chk(v == 6'(exp), "R7 status bits", v, exp);
        chk(int_n == 1'b1, "R7 read clears int", int_n, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] v;
        logic [3:0] swp;
        int cyc, exp_t, acc, deb, gl, seed;
        bit me, ig;
        seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(sw_en == 4'b0, "R1 sw_en", sw_en, 0);
        chk(int_n && mic_present_n, "R1 int/mic high", {int_n, mic_present_n}, 3);
        chk(asleep, "R1 asleep", asleep, 1);
        chk(!key_en && !fm_en, "R1 key/fm low", {key_en, fm_en}, 0);
        reg_read(2'd1, v);
        chk(v == 6'h10, "R1 control reset value", v, 'h10);

        // R2 R3 R4 R5 R6: default debounce, mic on sleeve
        detect(2'b01, 0, cyc, swp, me, ig);
        exp_t = 4 * (90 + CMS);
        chk_win("R2 R3 detect time 90ms", cyc, exp_t - 6, exp_t + 12);
        chk(swp == 4'b1001, "R5 R4 sw before int", swp, 4'b1001);
        chk(!me, "R5 mic not before int", me, 0);
        chk(mic_present_n == 1'b0, "R6 mic present 4-pole", mic_present_n, 0);
        reg_read(2'd3, v);
        chk(v == 6'd2, "R3 result mic sleeve", v, 2);
        clear_status(1);
        wr_ctrl(0, 0, 1, 2, 0);
        chk(key_en == 1'b1, "R11 key accepted 4-pole", key_en, 1);
        remove_check(0, 4'b0);
        reg_read(2'd3, v);
        chk(v == 6'd0, "R8 result cleared", v, 0);
        clear_status(2);

        // R13 fm
        wr_ctrl(0, 1, 0, 2, 0);
        chk(fm_en == 1'b1, "R13 fm on", fm_en, 1);
        wr_ctrl(0, 0, 0, 2, 0);
        chk(fm_en == 1'b0, "R13 fm off", fm_en, 0);

        // R4 R6 R11: three-contact with 2'b11, 30 ms debounce
        wr_ctrl(0, 0, 0, 1, 0);
        detect(2'b11, 0, cyc, swp, me, ig);
        exp_t = 4 * (30 + CMS);
        chk_win("R2 detect time 30ms", cyc, exp_t - 6, exp_t + 12);
        chk(swp == 4'b0100, "R4 sw 3-pole", swp, 4'b0100);
        chk(mic_present_n == 1'b1, "R6 no mic 3-pole", mic_present_n, 1);
        wr_ctrl(0, 0, 1, 1, 0);
        chk(key_en == 1'b0, "R11 key refused 3-pole", key_en, 0);
        clear_status(1);
        remove_check(0, 4'b0);
        clear_status(2);

        // R9 removal during debounce
        wr_ctrl(0, 0, 0, 2, 0);
        trig_n = 1'b0;
        repeat (160) @(negedge clk);
        trig_n = 1'b1;
        repeat (400) @(negedge clk);
        chk(int_n == 1'b1, "R9 no int on debounce removal", int_n, 1);
        chk(asleep == 1'b0, "R9 waits for stable low", asleep, 0);
        detect(2'b10, 0, cyc, swp, me, ig);
        exp_t = 4 * (90 + CMS);
        chk_win("R9 full debounce after return", cyc, exp_t - 6, exp_t + 12);
        chk(swp == 4'b0110, "R4 sw mic ring2", swp, 4'b0110);
        clear_status(1);
        remove_check(0, 4'b0);
        clear_status(2);

        // R8 removal during classification
        mic_loc = 2'b01;
        trig_n = 1'b0;
        repeat (4 * (90 + 20)) @(negedge clk);
        chk(int_n == 1'b1, "R8 no int yet in classify", int_n, 1);
        remove_check(0, 4'b0);
        clear_status(2);

        // R12 host start
        mic_loc = 2'b10;
        wr_ctrl(0, 0, 0, 2, 1);
        reg_read(2'd1, v);
        chk(v[5] == 1'b0, "R12 start reads 0", v[5], 0);
        cyc = 1;
        while (int_n && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk_win("R12 start skips debounce", cyc, 4 * CMS - 8, 4 * CMS + 12);
        chk(sw_en == 4'b0110, "R12 sw after start", sw_en, 4'b0110);
        clear_status(1);
        trig_n = 1'b0;
        repeat (3) @(negedge clk);
        remove_check(0, 4'b0);
        clear_status(2);

        // R10 manual override
        reg_write(2'd2, 6'b001010);
        wr_ctrl(1, 0, 0, 0, 0);
        chk(sw_en == 4'b1010, "R10 override drives sw", sw_en, 4'b1010);
        detect(2'b01, 0, cyc, swp, me, ig);
        chk(sw_en == 4'b1010, "R10 sw frozen at insert", sw_en, 4'b1010);
        chk_win("R2 detect time 0ms", cyc, 4 * CMS - 6, 4 * CMS + 12);
        clear_status(1);
        remove_check(1, 4'b1010);
        repeat (300) @(negedge clk);
        chk(asleep == 1'b0, "R10 no sleep in manual", asleep, 0);
        wr_ctrl(0, 0, 0, 2, 0);
        @(negedge clk);
        chk(asleep == 1'b1, "R10 sleep after manual off", asleep, 1);
        chk(sw_en == 4'b0, "R10 sw back to sequencer", sw_en, 0);
        clear_status(2);

        // random trials
        for (int t = 0; t < 12; t++) begin
            deb = $urandom_range(0, 3);
            gl  = (deb == 0) ? 0 : $urandom_range(0, 3);
            v   = 6'($urandom_range(0, 3));
            wr_ctrl(0, 0, 0, deb, 0);
            detect(v[1:0], gl, cyc, swp, me, ig);
            acc   = exp_acc(v[1:0]);
            exp_t = 4 * (exp_deb(deb) + CMS);
            chk(!ig, "R2 R9 no int during glitches", ig, 0);
            chk_win("R2 R3 random detect time", cyc, exp_t - 6, exp_t + 12);
            chk(swp == 4'(exp_sw(acc)), "R4 R5 random routing", swp, exp_sw(acc));
            chk(mic_present_n == (acc == 1), "R6 random mic flag", mic_present_n, acc == 1);
            reg_read(2'd3, v);
            chk(v == 6'(acc), "R3 random result", v, acc);
            clear_status(1);
            remove_check(0, 4'b0);
            clear_status(2);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule